// File: doc/BRIEF.md
# Cascadable Reload Timer Set

Four 8-bit down-counters, each with a reload latch, a count-stop bit and a selectable count source. They divide their source by n+1, where n is the latch value. Timers 1 and 2 form one pair and timers 3 and 4 form another. In each pair the first timer can serve as a prescaler for the second. The count sources are fractions of the block clock (clk/2, clk/16, clk/4096), the overflow of the partner timer, or rising edges on external pins: a timer-2 pin, a timer-3 pin and a horizontal-sync input.

The block also times the oscillator-stabilisation wait. Reset forces timers 3 and 4 into a cascade, loads them with fixed preset values and drives timer 3 from clk/16. A stop request forces the same cascade and presets, but timer 3 keeps the source its mode register selects. In both cases `osc_stable` stays low until timer 4 overflows.

A flat register port gives access to the four latches and the two mode registers. Each overflow produces a one-cycle interrupt request pulse.

Top module: `tmr_cascade_set`

## Requirements
- R1: On each count pulse a running timer with a nonzero count decrements by one, so the interval between its interrupt pulses is (n+1) source periods.
- R2: Writing a timer address (0..3 for timers 1..4) loads both the latch and the counter in the same clock edge. Reading addresses 0..3 returns the live count, and reading 4 and 5 returns the mode registers.
- R3: A count pulse that arrives while the count is 00 reloads the counter from its latch. The timer's bit of `irq` (bit k-1 for timer k) then pulses high for exactly one cycle after that edge.
- R4: Timer 1 counts clk/16 when mode12 bit 0 is 0 and clk/4096 when it is 1.
- R5: Timer 2 counts rising edges of `tim2_pin` when mode12 bit 1 is 1. When bit 1 is 0, mode12 bit 2 selects clk/16 (value 0) or timer 1 overflow (value 1).
- R6: Timer 3 counts clk/16 when mode34 bit 0 is 0, and an external source when it is 1. For the external source, mode34 bit 1 selects `tim3_pin` (0) or `hsync_pin` (1). Timer 4 counts clk/2 when mode34 bit 2 is 1. When bit 2 is 0, mode34 bit 3 selects timer 3 overflow (0) or clk/16 (1).
- R7: Stop bits freeze a timer's count while set: mode12 bit 3 for timer 1, mode12 bit 4 for timer 2, mode34 bit 4 for timer 3, mode34 bit 5 for timer 4.
- R8: After reset, timer 3 holds FF, timer 4 holds 07, both mode registers are 0 and `osc_stable` is low. Timer 4 counts timer 3 overflows and timer 3 counts clk/16. `osc_stable` rises on the first timer 4 overflow, 2048 x 16 = 32768 cycles after reset release.
- R9: A `stop_req` pulse while `osc_stable` is high forces timer 3 to FF and timer 4 to 07 and drops `osc_stable`. It does not force timer 3's source, which follows mode34. `osc_stable` rises again at the next timer 4 overflow.
- R10: An external input is synchronised through two flops and edge-detected. A rising edge is counted on the third clock edge after it arrives, and falling edges are not counted.
- R11: While `osc_stable` is low, register writes to the timer 3 and timer 4 latches are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| stop_req | input | 1 | Request to enter the stabilisation wait |
| tim2_pin | input | 1 | External clock for timer 2 |
| tim3_pin | input | 1 | External clock for timer 3 |
| hsync_pin | input | 1 | Horizontal sync, alternative timer 3 clock |
| irq | output | 4 | One-cycle overflow pulses, bit k-1 for timer k |
| osc_stable | output | 1 | High once the stabilisation wait has ended |

## Verification
Results have three latencies:
- **Register writes:** a write is visible on `rdata` one edge later.
- **Interrupts:** an overflow pulse appears on `irq` one cycle after the counting edge.
- **External edges:** an external rising edge changes the count on the third edge.

The prescaler phase is not visible at the ports, so divider checks measure the spacing between successive interrupt pulses, which must equal (n+1) source periods. For external pins the bench reads the count two edges and three edges after the pin rises. It expects no change at the first read and the decrement at the second. The stabilisation wait is timed from reset release or from the stop request, with a window of one clk/16 period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE12 = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MODE34 = 3'd5;

  localparam int M12_W        = 5;
  localparam int M12_T1_SLOW  = 0;
  localparam int M12_T2_EXT   = 1;
  localparam int M12_T2_CHAIN = 2;
  localparam int M12_T1_STOP  = 3;
  localparam int M12_T2_STOP  = 4;

  localparam int M34_W        = 6;
  localparam int M34_T3_EXT   = 0;
  localparam int M34_T3_HSYNC = 1;
  localparam int M34_T4_FAST  = 2;
  localparam int M34_T4_DIV16 = 3;
  localparam int M34_T3_STOP  = 4;
  localparam int M34_T4_STOP  = 5;

  localparam int NUM_TMR = 4;
  localparam int NUM_EXT = 3;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int FAST_LOG = 1,
  parameter int MID_LOG  = 4,
  parameter int SLOW_LOG = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_mid,
  output logic tick_slow
);
  localparam int DW = SLOW_LOG;

  logic [DW-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_fast = &div_q[FAST_LOG-1:0];
  assign tick_mid  = &div_q[MID_LOG-1:0];
  assign tick_slow = &div_q[SLOW_LOG-1:0];
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise[i] = s2_q & ~prev_q;
  end
endmodule

// File: rtl/tmr_down8.sv
module tmr_down8 #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         pulse,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] latch_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d, lat_q, lat_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign ovf_o   = pulse & ~load & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    lat_d = lat_q;
    if (load) begin
      cnt_d = load_val;
      lat_d = load_val;
    end else if (pulse) begin
      cnt_d = at_zero ? lat_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
      lat_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = lat_q;

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1); // R1
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_o == $past(load_val) && latch_o == $past(load_val))); // R2
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !load && cnt_o == '0) |=> cnt_o == $past(latch_o)); // R3
endmodule

// File: rtl/tmr_cascade_set.sv
module tmr_cascade_set
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] PRE_HI = 8'hFF,
  parameter logic [CNT_W-1:0] PRE_LO = 8'h07,
  parameter int FAST_LOG = 1,
  parameter int MID_LOG  = 4,
  parameter int SLOW_LOG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              stop_req,
  input  logic              tim2_pin,
  input  logic              tim3_pin,
  input  logic              hsync_pin,
  output logic [NUM_TMR-1:0] irq,
  output logic              osc_stable
);
  logic tick_fast, tick_mid, tick_slow;
  logic [NUM_EXT-1:0] ext_rise;
  logic [M12_W-1:0] m12_q, m12_d;
  logic [M34_W-1:0] m34_q, m34_d;
  logic hold_q, hold_d, free_q, free_d;
  logic enter, release_w;
  logic [NUM_TMR-1:0] src, run, pulse, ovf, load, irq_q;
  logic [CNT_W-1:0] cnt [NUM_TMR];
  logic [CNT_W-1:0] lat [NUM_TMR];
  logic [CNT_W-1:0] ld_val [NUM_TMR];
  logic ext3;

  tmr_prescale #(.FAST_LOG(FAST_LOG), .MID_LOG(MID_LOG), .SLOW_LOG(SLOW_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .tick_fast(tick_fast), .tick_mid(tick_mid), .tick_slow(tick_slow)
  );

  tmr_edge_sync #(.N(NUM_EXT)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin({hsync_pin, tim3_pin, tim2_pin}),
    .rise(ext_rise)
  );

  // source selection, cascade forced while waiting for the oscillator
  assign ext3 = m34_q[M34_T3_HSYNC] ? ext_rise[2] : ext_rise[1];

  always_comb begin
    src[0] = m12_q[M12_T1_SLOW] ? tick_slow : tick_mid;
    src[1] = m12_q[M12_T2_EXT] ? ext_rise[0]
           : (m12_q[M12_T2_CHAIN] ? ovf[0] : tick_mid);
    src[2] = (hold_q && free_q) ? tick_mid
           : (m34_q[M34_T3_EXT] ? ext3 : tick_mid);
    src[3] = hold_q ? ovf[2]
           : (m34_q[M34_T4_FAST] ? tick_fast
           : (m34_q[M34_T4_DIV16] ? tick_mid : ovf[2]));
    run[0] = ~m12_q[M12_T1_STOP];
    run[1] = ~m12_q[M12_T2_STOP];
    run[2] = hold_q | ~m34_q[M34_T3_STOP];
    run[3] = hold_q | ~m34_q[M34_T4_STOP];
  end

  assign enter     = stop_req & ~hold_q;
  assign release_w = hold_q & ovf[3];

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [CNT_W-1:0] RV = (i == 2) ? PRE_HI : ((i == 3) ? PRE_LO : '0);
    localparam logic [CNT_W-1:0] PV = (i == 2) ? PRE_HI : PRE_LO;
    localparam bit FORCED = (i >= 2);
    logic wr_hit;

    assign wr_hit = wr_en && (addr == ADDR_W'(i)) && !(FORCED && hold_q);
    assign pulse[i] = src[i] & run[i];

    if (FORCED) begin : g_forced
      assign load[i]   = wr_hit | enter;
      assign ld_val[i] = enter ? PV : wdata;
    end else begin : g_plain
      assign load[i]   = wr_hit;
      assign ld_val[i] = wdata;
    end

    tmr_down8 #(.W(CNT_W), .RST_VAL(RV)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(load[i]), .load_val(ld_val[i]), .pulse(pulse[i]),
      .cnt_o(cnt[i]), .latch_o(lat[i]), .ovf_o(ovf[i])
    );
  end

  always_comb begin
    m12_d  = m12_q;
    m34_d  = m34_q;
    hold_d = hold_q;
    free_d = free_q;
    if (wr_en && addr == ADDR_MODE12) m12_d = wdata[M12_W-1:0];
    if (wr_en && addr == ADDR_MODE34) m34_d = wdata[M34_W-1:0];
    if (enter) begin
      hold_d = 1'b1;
      free_d = 1'b0;
    end else if (release_w) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m12_q  <= '0;
      m34_q  <= '0;
      hold_q <= 1'b1;
      free_q <= 1'b1;
      irq_q  <= '0;
    end else begin
      m12_q  <= m12_d;
      m34_q  <= m34_d;
      hold_q <= hold_d;
      free_q <= free_d;
      irq_q  <= ovf;
    end
  end

  always_comb begin
    case (addr)
      3'd0, 3'd1, 3'd2, 3'd3: rdata = cnt[addr[1:0]];
      ADDR_MODE12: rdata = CNT_W'(m12_q);
      ADDR_MODE34: rdata = CNT_W'(m34_q);
      default:     rdata = '0;
    endcase
  end

  assign irq        = irq_q;
  assign osc_stable = ~hold_q;

  AST_T1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m12_q[M12_T1_STOP] && !load[0]) |=> $stable(cnt[0])); // R7
  AST_STOP_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !hold_q) |=> (hold_q && cnt[2] == PRE_HI && cnt[3] == PRE_LO)); // R9
  AST_RELEASE_ON_T4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> irq_q[3]); // R8
  AST_HOLD_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> ($stable(lat[2]) && $stable(lat[3]))); // R11
endmodule

// File: tb/tmr_cascade_set_tb.sv
module tmr_cascade_set_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic stop_req = 1'b0;
  logic tim2_pin = 1'b0, tim3_pin = 1'b0, hsync_pin = 1'b0;
  logic [3:0] irq;
  logic osc_stable;
  int n_chk = 0, n_bad = 0;
  int seen [4];

  always #4 clk = ~clk;

  tmr_cascade_set u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .stop_req(stop_req), .tim2_pin(tim2_pin),
    .tim3_pin(tim3_pin), .hsync_pin(hsync_pin), .irq(irq),
    .osc_stable(osc_stable)
  );

  initial for (int k = 0; k < 4; k++) seen[k] = 0;
  always @(negedge clk) for (int k = 0; k < 4; k++) if (irq[k]) seen[k]++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic period(input int k, output int p);
    int c = 0;
    do @(negedge clk); while (!irq[k]);
    do begin @(negedge clk); c++; end while (!irq[k]);
    p = c;
  endtask

  task automatic pin_pulse(input int which);
    @(negedge clk);
    if (which == 2) tim2_pin = 1'b1; else if (which == 3) tim3_pin = 1'b1; else hsync_pin = 1'b1;
    repeat (4) @(negedge clk);
    tim2_pin = 1'b0; tim3_pin = 1'b0; hsync_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_stable(output int c);
    c = 0;
    while (!osc_stable) begin @(negedge clk); c++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, p, c, b;
    int ns [9] = '{0, 1, 2, 3, 4, 7, 15, 31, 200};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    #1 check("R8 osc_stable at reset", osc_stable, 0);
    rd(3'd2, v); check("R8 timer3 preset", v, 255);
    rd(3'd3, v); check("R8 timer4 preset", v, 7);
    rd(3'd0, v); check("R8 timer1 reset", v, 0);
    rd(3'd5, v); check("R8 mode34 reset", v, 0);
    wait_stable(c);
    check_rng("R8 reset wait length", c + 3, 32760, 32776);

    // R1 R3 R4: timer1 on clk/16, sweep latch values
    wr(3'd4, 8'h10);
    for (int i = 0; i < 9; i++) begin
      wr(3'd0, ns[i][7:0]);
      #1 check("R2 write loads counter", rdata, ns[i]);
      period(0, p);
      check("R1 R3 timer1 clk/16 period", p, (ns[i] + 1) * 16);
    end
    // R4 clk/4096
    wr(3'd4, 8'h11);
    wr(3'd0, 8'd1);
    period(0, p); check("R4 timer1 clk/4096 period", p, 8192);
    rd(3'd4, v); check("R2 mode12 readback", v, 17);

    // R5 timer2 chained on timer1
    wr(3'd4, 8'h04);
    wr(3'd0, 8'd1);
    wr(3'd1, 8'd2);
    period(1, p); check("R5 timer2 chained period", p, 96);
    // R5 timer2 on clk/16
    wr(3'd4, 8'h08);
    wr(3'd1, 8'd4);
    period(1, p); check("R5 timer2 clk/16 period", p, 80);

    // R5 R10 timer2 external pin
    wr(3'd4, 8'h0A);
    wr(3'd1, 8'd3);
    @(negedge clk); tim2_pin = 1'b1;
    @(posedge clk); @(posedge clk); #1 check("R10 not counted after two edges", rdata, 3);
    @(posedge clk); #1 check("R10 counted on third edge", rdata, 2);
    repeat (3) @(negedge clk); tim2_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(3'd1, v); check("R10 falling edge ignored", v, 2);
    pin_pulse(2); pin_pulse(2);
    rd(3'd1, v); check("R5 external count to zero", v, 0);
    b = seen[1];
    pin_pulse(2);
    rd(3'd1, v); check("R3 reload after zero", v, 3);
    check("R3 timer2 single irq pulse", seen[1] - b, 1);

    // R6 timer3 external sources
    wr(3'd5, 8'h23);
    wr(3'd2, 8'd2);
    pin_pulse(3); pin_pulse(3);
    rd(3'd2, v); check("R6 timer3 pin ignored in hsync mode", v, 2);
    pin_pulse(1);
    rd(3'd2, v); check("R6 timer3 counts hsync", v, 1);
    wr(3'd5, 8'h21);
    pin_pulse(3);
    rd(3'd2, v); check("R6 timer3 counts its pin", v, 0);
    // R6 timer4 sources
    wr(3'd5, 8'h14);
    wr(3'd3, 8'd4);
    period(3, p); check("R6 timer4 clk/2 period", p, 10);
    wr(3'd5, 8'h18);
    wr(3'd3, 8'd1);
    period(3, p); check("R6 timer4 clk/16 period", p, 32);
    wr(3'd5, 8'h00);
    wr(3'd2, 8'd0);
    wr(3'd3, 8'd2);
    period(3, p); check("R6 timer4 on timer3 overflow", p, 48);

    // R7 stop bits
    wr(3'd4, 8'h18);
    wr(3'd0, 8'd9);
    repeat (100) @(negedge clk);
    rd(3'd0, v); check("R7 timer1 frozen", v, 9);
    wr(3'd5, 8'h10);
    wr(3'd2, 8'd6);
    repeat (100) @(negedge clk);
    rd(3'd2, v); check("R7 timer3 frozen", v, 6);

    // R9 R11 stop request
    wr(3'd5, 8'h03);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    #1 check("R9 osc_stable drops", osc_stable, 0);
    rd(3'd3, v); check("R9 timer4 preset", v, 7);
    wr(3'd2, 8'd5);
    rd(3'd2, v); check("R11 timer3 write ignored in wait", v, 255);
    repeat (100) @(negedge clk);
    rd(3'd2, v); check("R9 clk/16 not forced", v, 255);
    check("R9 still waiting", osc_stable, 0);
    pin_pulse(1);
    rd(3'd2, v); check("R9 timer3 follows mode source", v, 254);
    wr(3'd5, 8'h00);
    wait_stable(c);
    check_rng("R9 stop wait length", c, 32700, 32800);
    wr(3'd3, 8'd9);
    rd(3'd3, v); check("R11 writes accepted after wait", v, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule